// File: doc/BRIEF.md
# Edge Trigger Priority Controller

This block turns eight active-low trigger pins into a stream of interrupt vector numbers for a code sequencer. Each pin goes through a synchronizer and a debounce filter whose stable-time limit is chosen by a single long/short select input. Rising and falling edges of the filtered level are detected separately. Each edge has its own enable bit, and an enabled edge is latched as a pending event.

On every clock the block grants at most one request and presents its vector for one cycle with a valid strobe. The requests are the pending edges, a power-on initialization request and a software jump request that carries its own vector. The order is fixed. Power-on initialization comes first and the software jump comes last. Between them the trigger events are ordered by pin, with the falling edge of a pin ahead of its rising edge.

The enable bits sit in two 8-bit registers. Software may rewrite either register at any time. A cleared bit blocks new edges and also drops an event that is already pending.

Top module: `trig_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, `vec_valid_o` is low. The first grant after reset release is vector 32, because the power-on request is pending out of reset.
- R2: A pin level change is accepted only after the synchronized pin has differed from the accepted level for the full debounce limit. A pulse shorter than the limit produces no vector. An accepted change produces its vector between limit and limit+6 clocks after the pin moves.
- R3: `deb_long_i`=0 selects the limit DEB_SHORT and `deb_long_i`=1 selects DEB_LONG. A pulse lasting between the two limits passes in short mode and is filtered out in long mode.
- R4: Vector map, for pins numbered 0..7 (pin k is `trig_n_i[k]`): the falling edges of pins 0..3 give vectors 0..3 and their rising edges give 4..7. The falling edges of pins 4..7 give 8..11 and their rising edges give 12..15.
- R5: Register 0 holds the falling-edge enables of pins 0..3 in bits 3..0 (pin k at bit k) and their rising-edge enables in bits 7..4 (pin k at bit 4+k). Register 1 holds the same fields for pins 4..7. An edge whose enable bit is 0 produces no vector.
- R6: Both enable registers reset to 0xFF, so every edge is enabled.
- R7: Pending trigger events are granted one per clock, in order of ascending pin number. Within one pin the falling edge goes first.
- R8: A pulse on `poi_req_i` makes the power-on request pending from the next clock. It is then granted (vector 32) ahead of every pending trigger and jump.
- R9: A pending event stays latched until it is granted, and each accepted edge produces exactly one vector.
- R10: Writing 0 to an enable bit drops an event already pending on that bit. Setting the bit again does not bring the event back.
- R11: A pulse on `jump_req_i` latches `jump_vec_i`. The jump is granted only when no power-on or trigger event is pending, and its vector is the latched value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n_i | input | 8 | Active-low trigger pins |
| deb_long_i | input | 1 | 1 selects the long debounce limit |
| en_wr_i | input | 2 | Write strobe per enable register |
| en_wdata_i | input | 8 | Data written to the strobed enable register |
| poi_req_i | input | 1 | Power-on initialization request pulse |
| jump_req_i | input | 1 | Software jump request pulse |
| jump_vec_i | input | 11 | Vector carried by the jump request |
| vec_valid_o | output | 1 | One-cycle strobe: `vec_o` holds a granted vector |
| vec_o | output | 11 | Granted vector number |

## Verification
The hardest situation to reach from the ports is several requests pending in the same cycle while another class of request arrives during the drain. Without that, the fixed ordering and the power-on override are never exercised. The stimulus moves a chosen set of pins in the same clock, so their equal debounce paths deliver the edges together. It then watches for the first granted vector and raises a power-on, jump or enable-clear action at that moment, so the action lands while the rest of the set is still pending. Random toggle masks repeat the coincident-edge case across many pin subsets, mixing rising and falling edges.

// File: rtl/trig_pkg.sv
// Shared constants, types and the event-slot mapping for the trigger
// vector controller. Assumes pins are grouped four to an enable register.
package trig_pkg;

    localparam int VEC_W   = 11;   // vector number width
    localparam int POI_VEC = 32;   // power-on initialization vector
    localparam int GRP     = 4;    // pins per enable register

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_POI  = 2'd1,
        SRC_TRIG = 2'd2,
        SRC_JUMP = 2'd3
    } src_e;

    // Event slot of a pin edge. The slot equals both the enable bit index
    // in the concatenated enable registers and the vector number.
    function automatic int evt_slot(input int pin, input bit rise);
        return (pin / GRP) * 2 * GRP + (rise ? GRP : 0) + (pin % GRP);
    endfunction

endpackage

// File: rtl/trig_debounce.sv
// One-pin synchronizer, debounce filter and edge detector.
// Assumes SYNC_STAGES >= 2 and lim_i >= 2. The idle (released) level is 1.
module trig_debounce #(
    parameter int CNT_W       = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_n_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             fall_o,
    output logic             rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   lvl_q;
    logic                   lvl_d_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
    end

    // Accept a new level after it has differed for lim_i samples in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (sync_q[SYNC_STAGES-1] == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q >= lim_i - CNT_W'(1)) begin
            cnt_q <= '0;
            lvl_q <= sync_q[SYNC_STAGES-1];
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Keep the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d_q <= 1'b1;
        else        lvl_d_q <= lvl_q;
    end

    assign fall_o = lvl_d_q & ~lvl_q;
    assign rise_o = ~lvl_d_q & lvl_q;

endmodule

// File: rtl/trig_pend.sv
// Pending-event flags, one per event slot. An edge sets its flag only while
// its enable is 1. A grant clears the flag, and a cleared enable drops it.
module trig_pend #(
    parameter int NEVT = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] set_i,
    input  logic [NEVT-1:0] en_i,
    input  logic [NEVT-1:0] clr_i,
    output logic [NEVT-1:0] pend_o
);

    logic [NEVT-1:0] pend_q;

    // Latch enabled edges, drop granted or disabled ones.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= ((pend_q & ~clr_i) | set_i) & en_i;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/trig_pick.sv
// Fixed-priority selector: power-on first, then trigger events by ascending
// pin with falling before rising, then the software jump. Purely combinational.
module trig_pick
    import trig_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic               poi_i,
    input  logic [2*NPINS-1:0] pend_i,
    input  logic               jump_i,
    input  logic [VEC_W-1:0]   jump_vec_i,
    output src_e               src_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic [2*NPINS-1:0] clr_o
);

    // Walk the priority chain and pick the first active request.
    always_comb begin
        logic hit;
        hit   = 1'b0;
        src_o = SRC_NONE;
        vec_o = '0;
        clr_o = '0;
        if (poi_i) begin
            hit   = 1'b1;
            src_o = SRC_POI;
            vec_o = VEC_W'(POI_VEC);
        end
        for (int p = 0; p < NPINS; p++) begin
            for (int r = 0; r < 2; r++) begin
                if (!hit && pend_i[evt_slot(p, r == 1)]) begin
                    hit = 1'b1;
                    src_o = SRC_TRIG;
                    vec_o = VEC_W'(evt_slot(p, r == 1));
                    clr_o[evt_slot(p, r == 1)] = 1'b1;
                end
            end
        end
        if (!hit && jump_i) begin
            src_o = SRC_JUMP;
            vec_o = jump_vec_i;
        end
    end

endmodule

// File: rtl/trig_vector_ctrl.sv
// Edge trigger priority controller top. Debounces active-low pins, latches
// enabled edges and issues one vector per clock in fixed priority order.
// Assumes NPINS is a multiple of 4 and both debounce limits are >= 2.
module trig_vector_ctrl
    import trig_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int DEB_SHORT   = 1200,
    parameter int DEB_LONG    = 150000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     trig_n_i,
    input  logic                 deb_long_i,
    input  logic [NPINS/4-1:0]   en_wr_i,
    input  logic [7:0]           en_wdata_i,
    input  logic                 poi_req_i,
    input  logic                 jump_req_i,
    input  logic [VEC_W-1:0]     jump_vec_i,
    output logic                 vec_valid_o,
    output logic [VEC_W-1:0]     vec_o
);

    localparam int NREG  = NPINS / GRP;
    localparam int NEVT  = 2 * NPINS;
    localparam int CNT_W = $clog2(DEB_LONG + 1);

    logic [NEVT-1:0]  en_q;
    logic [NEVT-1:0]  set_evt;
    logic [NEVT-1:0]  pend_q;
    logic [NEVT-1:0]  clr_evt;
    logic [CNT_W-1:0] lim;
    logic             poi_pend_q;
    logic             jump_pend_q;
    logic [VEC_W-1:0] jump_vec_q;
    logic             gnt_trig_q;
    src_e             pick_src;
    logic [VEC_W-1:0] pick_vec;

    assign lim = deb_long_i ? CNT_W'(DEB_LONG) : CNT_W'(DEB_SHORT);

    // One enable register per group of four pins.
    for (genvar g = 0; g < NREG; g++) begin : g_en
        // Load the register on its write strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)          en_q[g*8 +: 8] <= 8'hFF;
            else if (en_wr_i[g]) en_q[g*8 +: 8] <= en_wdata_i;
        end
    end

    // One debounce and edge detector per pin, mapped onto event slots.
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic fall, rise;
        trig_debounce #(
            .CNT_W      (CNT_W),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_n_i(trig_n_i[p]),
            .lim_i  (lim),
            .fall_o (fall),
            .rise_o (rise)
        );
        assign set_evt[evt_slot(p, 1'b0)] = fall;
        assign set_evt[evt_slot(p, 1'b1)] = rise;
    end

    trig_pend #(.NEVT(NEVT)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_evt),
        .en_i  (en_q),
        .clr_i (clr_evt),
        .pend_o(pend_q)
    );

    trig_pick #(.NPINS(NPINS)) u_pick (
        .poi_i     (poi_pend_q),
        .pend_i    (pend_q & en_q),
        .jump_i    (jump_pend_q),
        .jump_vec_i(jump_vec_q),
        .src_o     (pick_src),
        .vec_o     (pick_vec),
        .clr_o     (clr_evt)
    );

    // Power-on request: pending out of reset, re-armed by the request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                  poi_pend_q <= 1'b1;
        else if (poi_req_i)          poi_pend_q <= 1'b1;
        else if (pick_src == SRC_POI) poi_pend_q <= 1'b0;
    end

    // Software jump request with its captured vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_pend_q <= 1'b0;
            jump_vec_q  <= '0;
        end else if (jump_req_i) begin
            jump_pend_q <= 1'b1;
            jump_vec_q  <= jump_vec_i;
        end else if (pick_src == SRC_JUMP) begin
            jump_pend_q <= 1'b0;
        end
    end

    // Register the granted vector and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_o <= 1'b0;
            vec_o       <= '0;
            gnt_trig_q  <= 1'b0;
        end else begin
            vec_valid_o <= (pick_src != SRC_NONE);
            gnt_trig_q  <= (pick_src == SRC_TRIG);
            if (pick_src != SRC_NONE) vec_o <= pick_vec;
        end
    end

endmodule

// File: rtl/trig_vector_ctrl_chk.sv
// Assertion checker for trig_vector_ctrl, attached by bind below.
module trig_vector_ctrl_chk
    import trig_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vec_valid_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic               poi_pend_q,
    input logic [2*NPINS-1:0] pend_q,
    input logic [2*NPINS-1:0] en_q,
    input logic               gnt_trig_q
);

    localparam int SW = $clog2(2 * NPINS);

    logic [1:0]         post_q;
    logic [2*NPINS-1:0] en_d_q;

    // Count clocks since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)            post_q <= 2'd0;
        else if (post_q != 2'd3) post_q <= post_q + 2'd1;
    end

    // Enable value seen by the selector in the grant cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d_q <= '1;
        else        en_d_q <= en_q;
    end

    AST_POI_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (post_q == 2'd1) |-> (vec_valid_o && vec_o == VEC_W'(POI_VEC))); // R1

    AST_POI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && vec_o != VEC_W'(POI_VEC)) |-> !$past(poi_pend_q)); // R8

    AST_TRIG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && gnt_trig_q) |-> en_d_q[vec_o[SW-1:0]]); // R5

    AST_GRANT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid_o && gnt_trig_q) |-> !pend_q[vec_o[SW-1:0]]); // R9

endmodule

bind trig_vector_ctrl trig_vector_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_valid_o(vec_valid_o),
    .vec_o      (vec_o),
    .poi_pend_q (poi_pend_q),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .gnt_trig_q (gnt_trig_q)
);

// File: tb/trig_vector_ctrl_test.sv
// Bench for trig_vector_ctrl: directed corner cases plus seeded random
// toggle masks, checked against vectors computed from the requirements.
module trig_vector_ctrl_test;

    localparam int SHORT = 4;
    localparam int LONG  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  trig_n = 8'hFF;
    logic        deb_long = 1'b0;
    logic [1:0]  en_wr = 2'b00;
    logic [7:0]  en_wdata = 8'h00;
    logic        poi_req = 1'b0;
    logic        jump_req = 1'b0;
    logic [10:0] jump_vec = '0;
    logic        vec_valid_o;
    logic [10:0] vec_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    logic [10:0] got_q[$];
    int          got_cyc[$];
    int          exp_q[$];

    trig_vector_ctrl #(.NPINS(8), .DEB_SHORT(SHORT), .DEB_LONG(LONG)) uut (
        .clk(clk), .rst_n(rst_n), .trig_n_i(trig_n), .deb_long_i(deb_long),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .poi_req_i(poi_req),
        .jump_req_i(jump_req), .jump_vec_i(jump_vec),
        .vec_valid_o(vec_valid_o), .vec_o(vec_o)
    );

    always #4 clk = ~clk;

    // Cycle count and output capture, sampled between clock edges.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        if (vec_valid_o) begin
            got_q.push_back(vec_o);
            got_cyc.push_back(cyc);
        end
    end

    function automatic int fvec(int p);
        return (p < 4) ? p : 8 + (p - 4);
    endfunction

    function automatic int rvec(int p);
        return (p < 4) ? 4 + p : 12 + (p - 4);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        got_q.delete();
        got_cyc.delete();
        exp_q.delete();
    endtask

    // Compare captured vectors with the expected list, element by element.
    task automatic check_seq(string tag);
        check(got_q.size() == exp_q.size(), {tag, " count"}, got_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check(int'(got_q[i]) == exp_q[i], tag, int'(got_q[i]), exp_q[i]);
    endtask

    task automatic write_en(int r, logic [7:0] v);
        en_wr = 2'b00;
        en_wr[r] = 1'b1;
        en_wdata = v;
        tick(1);
        en_wr = 2'b00;
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 200 && !vec_valid_o; i++) @(negedge clk);
    endtask

    // Expected vectors when pins move from old to new, in priority order.
    task automatic push_edges(logic [7:0] oldv, logic [7:0] newv);
        for (int p = 0; p < 8; p++)
            if (oldv[p] != newv[p]) exp_q.push_back(newv[p] ? rvec(p) : fvec(p));
    endtask

    initial begin
        logic [7:0] nxt;
        int start;
        void'($urandom(32'h5EED_0042));
        // R1: quiet in reset, vector 32 first after release.
        tick(3);
        check(vec_valid_o == 1'b0, "R1 valid low in reset", vec_valid_o, 0);
        clear_obs();
        rst_n = 1'b1;
        tick(6);
        exp_q.push_back(32);
        check_seq("R1 first grant is POI");

        // R2/R4/R6: each pin alone, default enables, latency window.
        for (int p = 0; p < 8; p++) begin
            clear_obs();
            start = cyc;
            trig_n[p] = 1'b0;
            tick(SHORT + 10);
            exp_q.push_back(fvec(p));
            check_seq("R4 R6 falling vector");
            if (got_cyc.size() > 0)
                check(got_cyc[0] - start >= SHORT && got_cyc[0] - start <= SHORT + 6,
                      "R2 debounce latency", got_cyc[0] - start, SHORT + 4);
            clear_obs();
            trig_n[p] = 1'b1;
            tick(SHORT + 10);
            exp_q.push_back(rvec(p));
            check_seq("R4 rising vector");
        end

        // R2: a pulse shorter than the limit is filtered.
        clear_obs();
        trig_n[3] = 1'b0; tick(SHORT - 2); trig_n[3] = 1'b1;
        tick(30);
        check_seq("R2 glitch filtered");

        // R3: a 10-cycle pulse is filtered in long mode, accepted in short mode.
        deb_long = 1'b1;
        clear_obs();
        trig_n[2] = 1'b0; tick(10); trig_n[2] = 1'b1;
        tick(40);
        check_seq("R3 long filters pulse");
        clear_obs();
        start = cyc;
        trig_n[6] = 1'b0;
        tick(LONG + 10);
        exp_q.push_back(fvec(6));
        check_seq("R3 long accepts held press");
        if (got_cyc.size() > 0)
            check(got_cyc[0] - start >= LONG, "R3 long latency", got_cyc[0] - start, LONG + 4);
        clear_obs();
        trig_n[6] = 1'b1; tick(LONG + 10);
        deb_long = 1'b0;
        clear_obs();
        trig_n[2] = 1'b0; tick(10); trig_n[2] = 1'b1;
        tick(30);
        exp_q.push_back(fvec(2)); exp_q.push_back(rvec(2));
        check_seq("R3 short accepts pulse");

        // R5: disable rise of pin 1 (reg0 bit 5), fall of pin 5 (reg1 bit 1).
        write_en(0, 8'hDF);
        write_en(1, 8'hFD);
        clear_obs();
        trig_n[1] = 1'b0; tick(SHORT + 10); trig_n[1] = 1'b1; tick(SHORT + 10);
        exp_q.push_back(fvec(1));
        check_seq("R5 rise of pin 1 disabled");
        clear_obs();
        trig_n[5] = 1'b0; tick(SHORT + 10); trig_n[5] = 1'b1; tick(SHORT + 10);
        exp_q.push_back(rvec(5));
        check_seq("R5 fall of pin 5 disabled");
        write_en(0, 8'hFF);
        write_en(1, 8'hFF);

        // R7/R8: coincident falls on pins 0..3, POI raised at the first grant.
        clear_obs();
        trig_n[3:0] = 4'h0;
        wait_valid();
        poi_req = 1'b1; tick(1); poi_req = 1'b0;
        tick(10);
        exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(32);
        exp_q.push_back(2); exp_q.push_back(3);
        check_seq("R8 POI overtakes pending triggers");
        clear_obs();
        trig_n[3:0] = 4'hF; tick(SHORT + 12);
        push_edges(8'hF0, 8'hFF);
        check_seq("R7 coincident rises in order");

        // R11: jump alone, then jump behind pending triggers.
        clear_obs();
        jump_vec = 11'h5A5; jump_req = 1'b1; tick(1); jump_req = 1'b0;
        tick(4);
        exp_q.push_back(11'h5A5);
        check_seq("R11 idle jump");
        clear_obs();
        trig_n[5:4] = 2'b00;
        wait_valid();
        jump_vec = 11'h3C1; jump_req = 1'b1; tick(1); jump_req = 1'b0;
        tick(8);
        exp_q.push_back(8); exp_q.push_back(9); exp_q.push_back(11'h3C1);
        check_seq("R11 jump after triggers");
        clear_obs();
        trig_n[5:4] = 2'b11; tick(SHORT + 12);

        // R10/R9: clearing reg0 at the first grant drops the rest.
        clear_obs();
        trig_n[2:0] = 3'b000;
        wait_valid();
        write_en(0, 8'h00);
        tick(20);
        write_en(0, 8'hFF);
        tick(20);
        exp_q.push_back(0); exp_q.push_back(1);
        check_seq("R10 disabled pending dropped");
        clear_obs();
        trig_n[2:0] = 3'b111; tick(SHORT + 12);
        exp_q.push_back(4); exp_q.push_back(5); exp_q.push_back(6);
        check_seq("R9 one vector per edge");

        // R7: random toggle masks with mixed rising and falling edges.
        for (int it = 0; it < 40; it++) begin
            clear_obs();
            nxt = trig_n ^ 8'($urandom_range(1, 255));
            push_edges(trig_n, nxt);
            trig_n = nxt;
            tick(SHORT + 20);
            check_seq("R7 random priority order");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule